// File: doc/BRIEF.md
# Selectable Hall Pulse Output Generator

This block turns the three rotor-position sensor signals of a brushless motor into one speed-feedback pulse train. Two active-low select pins pick the format. The pulse train can follow the first sensor alone, or a synthesised signal that is the exclusive-OR of all three sensors. The synthesised signal changes level on every sensor transition, so it carries six transitions per electrical revolution. Either source can also be halved in frequency by a toggle stage that advances on the source's rising edges.

The output is modelled as an open-collector driver. `tachSink` high means the pin is pulled low. `tachSink` low means the pin is released and an external pull-up sets its level. A separate single-cycle strobe marks every transition of the synthesised signal, for a rotor-lock detector elsewhere in the chip. The sensor inputs arrive already synchronised to `clk`. The select pins are pulled up on the board, so an unconnected pin reads as 1.

A change on the select pins takes effect at the next transition of the synthesised signal. Every sensor transition is such a transition, so the output only moves at a sensor edge and never between them.

Top module: `hall_tach_out`

## Requirements
- R1: While `rstN` is low, `tachSink` is 0 (released) and `combPulse` is 0.
- R2: `tachSink` is 1 exactly when the selected source level is 0, and 0 when that level is 1.
- R3: With `selSrcN`=0 and `selDivN`=1, the output level equals the `hallA` value sampled at the most recent rising clock edge.
- R4: With `selSrcN`=1 and `selDivN`=1, the output level equals `hallA ^ hallB ^ hallC` sampled at the most recent rising clock edge.
- R5: With `selDivN`=0, the output level is a toggle state for the chosen source. The toggle state is 0 after reset and inverts on each rising edge of that source (first sensor for `selSrcN`=0, exclusive-OR signal for `selSrcN`=1).
- R6: Select pins at 1, which is the pulled-up open state, choose the three-sensor undivided format.
- R7: The select pins are captured in the first cycle after reset and again in every cycle that sees a transition of the exclusive-OR signal. Between such transitions, changing the pins leaves the output unchanged.
- R8: `combPulse` is 1 for exactly the one cycle after the clock edge that first samples a new exclusive-OR value, and 0 otherwise.
- R9: The first sensor value sampled after reset is taken as the reference. It produces no `combPulse` and does not advance either toggle state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hallA | input | 1 | First position sensor, synchronised |
| hallB | input | 1 | Second position sensor, synchronised |
| hallC | input | 1 | Third position sensor, synchronised |
| selDivN | input | 1 | 0: halve the chosen source; 1 (open): undivided |
| selSrcN | input | 1 | 0: first sensor only; 1 (open): three-sensor exclusive-OR |
| tachSink | output | 1 | 1 = output transistor sinking (pin low); 0 = released |
| combPulse | output | 1 | One-cycle strobe per exclusive-OR transition |

## Verification
The hold and toggle properties assume that the sensor inputs are already synchronous to `clk`. They also assume that the sensor inputs change only by one-step moves through the six valid rotor states, so each clock edge sees at most one transition. The stimulus moves the sensors only along that six-state cycle, in both rotation directions. It holds each state for at least two clock cycles and changes the select pins only while the sensors are steady. This keeps every observed transition attributable to a single sensor edge.

// File: rtl/hall_tach_pkg.sv
`timescale 1ns/1ps
package hall_tach_pkg;
  localparam int HALL_W = 3;

  typedef struct packed {
    logic primed;      // reference sample taken since reset
    logic combEdge;    // exclusive-OR signal changed this cycle
    logic riseSingle;  // first sensor rose this cycle
    logic riseComb;    // exclusive-OR signal rose this cycle
    logic useSingle;   // mode in force from this edge on: first sensor
    logic useDivided;  // mode in force from this edge on: halved
  } tachStrobe_t;
endpackage

// File: rtl/hall_tach_ctrl.sv
`timescale 1ns/1ps
module hall_tach_ctrl
  import hall_tach_pkg::*;
#(
  parameter int HALL_N = HALL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HALL_N-1:0] hall,
  input  logic              selDivN,
  input  logic              selSrcN,
  output tachStrobe_t       strb
);
  logic [HALL_N-1:0] prevHall;
  logic primed;
  logic modeSingle, modeDiv;
  logic combNow, combPrev, combEdge, loadMode;
  logic nextSingle, nextDiv;

  assign combNow    = ^hall;
  assign combPrev   = ^prevHall;
  assign combEdge   = primed & (combNow ^ combPrev);
  assign loadMode   = ~primed | combEdge;
  assign nextSingle = loadMode ? ~selSrcN : modeSingle;
  assign nextDiv    = loadMode ? ~selDivN : modeDiv;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevHall   <= '0;
      primed     <= 1'b0;
      modeSingle <= 1'b0;
      modeDiv    <= 1'b0;
    end else begin
      prevHall   <= hall;
      primed     <= 1'b1;
      modeSingle <= nextSingle;
      modeDiv    <= nextDiv;
    end
  end

  always_comb begin
    strb.primed     = primed;
    strb.combEdge   = combEdge;
    strb.riseSingle = primed & hall[0] & ~prevHall[0];
    strb.riseComb   = primed & combNow & ~combPrev;
    strb.useSingle  = nextSingle;
    strb.useDivided = nextDiv;
  end

  // Mode is only re-captured at an exclusive-OR transition (R7)
  p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !combEdge) |=> ($stable(modeSingle) && $stable(modeDiv)));
endmodule

// File: rtl/hall_tach_dp.sv
`timescale 1ns/1ps
module hall_tach_dp
  import hall_tach_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hallSingle,
  input  logic        hallComb,
  input  tachStrobe_t strb,
  output logic        outLevel,
  output logic        edgePulse
);
  logic divSingle, divComb;
  logic divSingleNext, divCombNext;
  logic srcLevel;

  assign divSingleNext = divSingle ^ strb.riseSingle;
  assign divCombNext   = divComb ^ strb.riseComb;

  always_comb begin
    if (strb.useDivided)
      srcLevel = strb.useSingle ? divSingleNext : divCombNext;
    else
      srcLevel = strb.useSingle ? hallSingle : hallComb;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divSingle <= 1'b0;
      divComb   <= 1'b0;
      outLevel  <= 1'b1;
      edgePulse <= 1'b0;
    end else begin
      divSingle <= divSingleNext;
      divComb   <= divCombNext;
      outLevel  <= srcLevel;
      edgePulse <= strb.combEdge;
    end
  end

  // Output only moves at a transition of the exclusive-OR signal (R7)
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.primed && !strb.combEdge) |=> $stable(outLevel));

  // Single-sensor toggle state holds without a rising edge (R5)
  p_div_single_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.riseSingle |=> $stable(divSingle));

  // Exclusive-OR toggle state inverts on a rising edge (R5)
  p_div_comb_flip_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.riseComb |=> (divComb != $past(divComb)));

  // Strobe follows each transition for one cycle (R8)
  p_pulse_on_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.combEdge |=> edgePulse);
  p_pulse_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.combEdge |=> !edgePulse);

  // Reference sample after reset gives no strobe (R9)
  p_prime_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.primed |=> !edgePulse);
endmodule

// File: rtl/hall_tach_out.sv
`timescale 1ns/1ps
module hall_tach_out
  import hall_tach_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic hallA,
  input  logic hallB,
  input  logic hallC,
  input  logic selDivN,
  input  logic selSrcN,
  output logic tachSink,
  output logic combPulse
);
  tachStrobe_t strb;
  logic outLevel;
  logic [HALL_W-1:0] hallVec;

  assign hallVec = {hallC, hallB, hallA};

  hall_tach_ctrl #(.HALL_N(HALL_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hall    (hallVec),
    .selDivN (selDivN),
    .selSrcN (selSrcN),
    .strb    (strb)
  );

  hall_tach_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .hallSingle (hallA),
    .hallComb   (^hallVec),
    .strb       (strb),
    .outLevel   (outLevel),
    .edgePulse  (combPulse)
  );

  assign tachSink = ~outLevel;

  // Released while in reset (R1)
  p_reset_release_r1: assert property (@(posedge clk)
    !rstN |=> (!tachSink && !combPulse));
endmodule

// File: tb/hall_tach_out_test.sv
`timescale 1ns/1ps
module hall_tach_out_test;
  logic clk = 1'b0;
  logic rstN, hallA, hallB, hallC, selDivN, selSrcN;
  logic tachSink, combPulse;

  int checks = 0;
  int fails = 0;

  // model state
  logic [2:0] prevV;
  logic mSingle, mDiv, dSingle, dComb, expLvl;
  logic [2:0] seq [6] = '{3'd5, 3'd1, 3'd3, 3'd2, 3'd6, 3'd4};
  int pos = 0;

  always #2 clk = ~clk;

  hall_tach_out uut (
    .clk(clk), .rstN(rstN), .hallA(hallA), .hallB(hallB), .hallC(hallC),
    .selDivN(selDivN), .selSrcN(selSrcN), .tachSink(tachSink), .combPulse(combPulse)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  function automatic logic pickLevel(input logic [2:0] v);
    if (mDiv) return mSingle ? dSingle : dComb;
    return mSingle ? v[0] : ^v;
  endfunction

  task automatic driveHall(input logic [2:0] v);
    {hallC, hallB, hallA} = v;
  endtask

  // one sensor move, then two sampled cycles
  task automatic stepHall(input logic [2:0] nv, input string req);
    logic edgeSeen;
    logic lvlBefore;
    edgeSeen = (^nv) != (^prevV);
    if (edgeSeen) begin
      mSingle = ~selSrcN;
      mDiv    = ~selDivN;
    end
    if (nv[0] && !prevV[0]) dSingle = ~dSingle;
    if ((^nv) && !(^prevV)) dComb = ~dComb;
    expLvl = pickLevel(nv);
    prevV = nv;
    driveHall(nv);
    @(negedge clk);
    check(tachSink, ~expLvl, req, "output after sensor move");
    check(combPulse, edgeSeen, "R8", "strobe on transition");
    lvlBefore = tachSink;
    @(negedge clk);
    check(combPulse, 1'b0, "R8", "strobe lasts one cycle");
    check(tachSink, lvlBefore, "R7", "output steady between moves");
  endtask

  task automatic rotate(input int n, input bit fwd, input string req);
    for (int i = 0; i < n; i++) begin
      pos = fwd ? (pos + 1) % 6 : (pos + 5) % 6;
      stepHall(seq[pos], req);
    end
  endtask

  task automatic testReset;
    rstN = 1'b0; selDivN = 1'b1; selSrcN = 1'b1;
    driveHall(seq[0]);
    repeat (3) @(negedge clk);
    check(tachSink, 1'b0, "R1", "released in reset");
    check(combPulse, 1'b0, "R1", "no strobe in reset");
  endtask

  task automatic testPrime;
    rstN = 1'b1;
    prevV = seq[0]; mSingle = 1'b0; mDiv = 1'b0; dSingle = 1'b0; dComb = 1'b0;
    @(negedge clk);
    check(combPulse, 1'b0, "R9", "reference sample gives no strobe");
    // open pins: three-sensor undivided, xor of 101 is 0 -> sinking
    check(tachSink, 1'b1, "R6", "open pins choose xor undivided");
    @(negedge clk);
    check(combPulse, 1'b0, "R9", "still no strobe");
    check(tachSink, 1'b1, "R2", "low level sinks");
  endtask

  task automatic testDefault;
    rotate(12, 1'b1, "R4");
  endtask

  task automatic testModeLatch;
    logic held;
    held = tachSink;
    selSrcN = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(tachSink, held, "R7", "pin change waits for transition");
    end
    rotate(1, 1'b1, "R3");
    rotate(6, 1'b1, "R3");
  endtask

  task automatic testSingleDiv;
    selDivN = 1'b0;
    @(negedge clk);
    rotate(12, 1'b1, "R5");
  endtask

  task automatic testCombDiv;
    selSrcN = 1'b1;
    @(negedge clk);
    rotate(12, 1'b0, "R5");
  endtask

  task automatic testBackToRaw;
    selDivN = 1'b1;
    @(negedge clk);
    rotate(6, 1'b0, "R2");
  endtask

  initial begin
    testReset();
    testPrime();
    testDefault();
    testModeLatch();
    testSingleDiv();
    testCombDiv();
    testBackToRaw();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule